// File: doc/BRIEF.md
# Multi-Rail Reset Supervisor Controller

This block is the digital core of a reset supervisor that watches several supply rails. It takes one synchronous undervoltage flag per rail from external comparators, an active-low push-button reset, and a watchdog service line with a separate enable strap. From these it produces a single system reset. The reset asserts as soon as any fault appears. It releases only after every rail is good and the push-button has been released, and that clean state has held for a hold-off period. The hold-off period is chosen by a 2-bit select.

Time is counted on a slow tick-enable input. With the default 1 kHz tick, the hold-off period and the watchdog period are counted in milliseconds. The push-button path has a two-flop synchronizer and a level filter that rejects short glitches. The watchdog service line is synchronized, and either of its edges services the watchdog. If the watchdog starves, the block produces a reset pulse of exactly one hold-off period and then resumes watching. A build parameter selects the output polarity. The internal reset state is the same for both polarities.

Top module: `sup_reset_ctrl`

## Requirements
- R1: When any undervoltage flag is 1 at a clock edge, the reset is asserted from that edge onward, with no hold-off delay.
- R2: A push-button low level that lasts at least MR_FILT_CYC cycles after the two synchronizer stages asserts reset. Reset stays asserted for as long as the button is held, regardless of ticks.
- R3: Once all flags are 0 and the button is high, reset releases on exactly the L-th tick, where L = HOLD_BASE << tsel_i. Code 0 gives 1x, code 1 gives 2x, code 2 gives 4x and code 3 gives 8x. The defaults are 50, 100, 200 and 400 ms, and code 2 is the nominal choice.
- R4: A fault that appears while the hold-off is being counted restarts the hold-off count from zero.
- R5: With the watchdog enabled and no service edge, the WD_TICKS-th tick asserts reset. Reset then releases after exactly L ticks, and the watchdog count starts again from zero.
- R6: Both rising and falling edges of wdi_i clear the watchdog count. The count is also held at zero while reset or the filtered push-button is active.
- R7: When wd_en_i is 0, the watchdog never asserts reset, however many ticks pass.
- R8: A push-button low pulse shorter than MR_FILT_CYC cycles is ignored and does not assert reset.
- R9: With ACTIVE_HIGH = 0, rst_o is 0 while reset is asserted. With ACTIVE_HIGH = 1, rst_o is 1 while reset is asserted. Both polarities carry the same internal state.
- R10: After rst_ni, reset is asserted and the hold-off count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | One-cycle time-base enable (1 kHz by default) |
| uv_i | input | N_UV | Synchronous undervoltage flags, 1 = rail low |
| mr_ni | input | 1 | Push-button reset, active low, asynchronous |
| wdi_i | input | 1 | Watchdog service line, asynchronous |
| wd_en_i | input | 1 | Watchdog enable strap, 0 = watchdog off |
| tsel_i | input | 2 | Hold-off period select code |
| rst_o | output | 1 | System reset, polarity set by ACTIVE_HIGH |

## Verification
Assertions inside the RTL check the following on every cycle:
- a raised undervoltage flag forces reset at the next edge;
- a reset release always coincides with a clean tick;
- the hold-off counter stays below its limit;
- the watchdog count is zero whenever it is held or disabled;
- the filter output rises only after a sustained low input.

Only the bench scenarios can show the following:
- the exact hold-off length for every select code;
- the restart of the hold-off count on a mid-count fault;
- rejection of a short push-button pulse;
- exact watchdog expiry and pulse length, and the watchdog re-arming after a pulse;
- the polarity of the two build variants.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    HOLD_X1 = 2'd0,
    HOLD_X2 = 2'd1,
    HOLD_X4 = 2'd2,
    HOLD_X8 = 2'd3
  } hold_sel_e;

  localparam int unsigned HOLD_MAX_MULT = 8;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sup_glitch_filt.sv
module sup_glitch_filt #(
  parameter int unsigned CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  output logic act_o
);
  localparam int unsigned CNT_W = $clog2(CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!low_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!act_q) begin
      if (cnt_q == CNT_W'(CYC - 1)) act_q <= 1'b1;
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end

  assign act_o = act_q;

  // filter output may only rise after a sustained low input
  assert_filter_sustained_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(low_i));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int unsigned TICKS = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic wdi_s_i,
  input  logic hold_i,
  output logic exp_o
);
  localparam int unsigned WD_W = $clog2(TICKS + 1);

  logic [WD_W-1:0] cnt_q;
  logic            wdi_d_q;
  logic            clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdi_d_q <= 1'b0;
    else         wdi_d_q <= wdi_s_i;
  end

  // either edge services; held while reset/button active or disabled
  assign clr   = hold_i | ~en_i | (wdi_s_i ^ wdi_d_q);
  assign exp_o = tick_i & ~clr & (cnt_q == WD_W'(TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (exp_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assert_wd_held_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
  assert_wd_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !exp_o);
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
#(
  parameter int unsigned N_UV        = 4,
  parameter bit          ACTIVE_HIGH = 1'b0,
  parameter int unsigned MR_FILT_CYC = 50,
  parameter int unsigned WD_TICKS    = 1600,
  parameter int unsigned HOLD_BASE   = 50
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [N_UV-1:0] uv_i,
  input  logic            mr_ni,
  input  logic            wdi_i,
  input  logic            wd_en_i,
  input  logic [1:0]      tsel_i,
  output logic            rst_o
);
  localparam int unsigned HOLD_W = $clog2(HOLD_BASE * HOLD_MAX_MULT + 1);

  logic [1:0]        sync_q;
  logic              mr_act, wd_exp, fault, rst_q;
  logic [HOLD_W-1:0] hcnt_q, hold_len;
  hold_sel_e         sel;

  sup_sync #(.W(2), .RST_VAL(2'b01)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wdi_i, mr_ni}),
    .q_o   (sync_q)
  );

  sup_glitch_filt #(.CYC(MR_FILT_CYC)) i_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .low_i (~sync_q[0]),
    .act_o (mr_act)
  );

  sup_wdog #(.TICKS(WD_TICKS)) i_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .en_i   (wd_en_i),
    .wdi_s_i(sync_q[1]),
    .hold_i (rst_q | mr_act),
    .exp_o  (wd_exp)
  );

  assign sel      = hold_sel_e'(tsel_i);
  assign hold_len = HOLD_W'(HOLD_BASE) << sel;
  assign fault    = (|uv_i) | mr_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b1;
      hcnt_q <= '0;
    end else if (fault || wd_exp) begin
      rst_q  <= 1'b1;
      hcnt_q <= '0;
    end else if (rst_q && tick_i) begin
      if (hcnt_q == hold_len - 1'b1) begin
        rst_q  <= 1'b0;
        hcnt_q <= '0;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  generate
    if (ACTIVE_HIGH) begin : g_pol_hi
      assign rst_o = rst_q;
    end else begin : g_pol_lo
      assign rst_o = ~rst_q;
    end
  endgenerate

  assert_uv_asserts_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|uv_i) |=> rst_q);
  assert_mr_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_act |=> rst_q);
  assert_release_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> $past(tick_i) && !$past(fault));
  assert_hold_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q < hold_len || $changed(tsel_i));
endmodule

// File: tb/test_sup_reset_ctrl.sv
module test_sup_reset_ctrl;
  localparam int unsigned FILT = 4;
  localparam int unsigned WD   = 20;
  localparam int unsigned BASE = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] uv = 4'b0;
  logic       mr_n = 1'b1;
  logic       wdi = 1'b0;
  logic       wd_en = 1'b0;
  logic [1:0] tsel = 2'd0;
  logic       rst_lo, rst_hi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sup_reset_ctrl #(.ACTIVE_HIGH(1'b0), .MR_FILT_CYC(FILT), .WD_TICKS(WD), .HOLD_BASE(BASE))
  i_sup_reset_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .uv_i(uv), .mr_ni(mr_n),
    .wdi_i(wdi), .wd_en_i(wd_en), .tsel_i(tsel), .rst_o(rst_lo)
  );

  sup_reset_ctrl #(.ACTIVE_HIGH(1'b1), .MR_FILT_CYC(FILT), .WD_TICKS(WD), .HOLD_BASE(BASE))
  i_sup_reset_ctrl_hi (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .uv_i(uv), .mr_ni(mr_n),
    .wdi_i(wdi), .wd_en_i(wd_en), .tsel_i(tsel), .rst_o(rst_hi)
  );

  // {uv[3:0], tsel[1:0], expected hold-off ticks[7:0]}
  localparam logic [13:0] VEC [5] = '{
    {4'b0001, 2'd0, 8'd5},
    {4'b0010, 2'd1, 8'd10},
    {4'b0100, 2'd2, 8'd20},
    {4'b1000, 2'd3, 8'd40},
    {4'b1111, 2'd0, 8'd5}
  };

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  // exp = 1 means reset asserted; both polarity variants are checked (R9)
  task automatic chk(input string req, input bit exp);
    n_chk++;
    if ((rst_lo !== ~exp) || (rst_hi !== exp)) begin
      n_fail++;
      $display("FAIL %s: rst_lo=%b rst_hi=%b expected lo=%b hi=%b",
               req, rst_lo, rst_hi, ~exp, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R10 reset state", 1'b1);
    rst_n = 1'b1;
    cyc(4);
    chk("R10 held without ticks", 1'b1);
    ticks(BASE - 1);
    chk("R10 hold-off from zero", 1'b1);
    ticks(1);
    chk("R10 released after hold-off", 1'b0);

    foreach (VEC[k]) begin
      uv   = VEC[k][13:10];
      tsel = VEC[k][9:8];
      cyc(1);
      chk("R1 immediate assert", 1'b1);
      ticks(3);
      chk("R1 held while rail low", 1'b1);
      uv = 4'b0;
      cyc(1);
      ticks(int'(VEC[k][7:0]) - 1);
      chk("R3 still held at L-1", 1'b1);
      ticks(1);
      chk("R3 released at L", 1'b0);
    end

    // R4 restart during hold-off
    tsel = 2'd1;
    uv = 4'b0100; cyc(1); uv = 4'b0;
    ticks(8);
    uv = 4'b0001; cyc(1); uv = 4'b0;
    ticks(9);
    chk("R4 count restarted", 1'b1);
    ticks(1);
    chk("R4 released after full restart", 1'b0);

    // R8 short button glitch
    tsel = 2'd0;
    mr_n = 1'b0; cyc(FILT - 2); mr_n = 1'b1;
    begin
      bit seen = 0;
      for (int i = 0; i < 12; i++) begin
        cyc(1);
        if (rst_lo == 1'b0) seen = 1;
      end
      n_chk++;
      if (seen) begin
        n_fail++;
        $display("FAIL R8: short pulse asserted reset, actual=1 expected=0");
      end
    end

    // R2 long button press
    mr_n = 1'b0;
    cyc(FILT + 6);
    chk("R2 button asserts", 1'b1);
    ticks(12);
    chk("R2 held while button low", 1'b1);
    mr_n = 1'b1;
    cyc(4);
    ticks(BASE - 1);
    chk("R2 held until hold-off", 1'b1);
    ticks(1);
    chk("R2 released after button", 1'b0);

    // R7 watchdog disabled
    ticks(WD + 10);
    chk("R7 disabled watchdog silent", 1'b0);

    // R6 both edges service
    wd_en = 1'b1;
    cyc(2);
    for (int r = 0; r < 4; r++) begin
      ticks(WD - 5);
      wdi = ~wdi;
      cyc(4);
    end
    chk("R6 serviced by both edges", 1'b0);

    // R5 starvation
    ticks(WD - 1);
    chk("R5 no expiry at WD-1", 1'b0);
    ticks(1);
    chk("R5 expiry asserts", 1'b1);
    ticks(BASE - 1);
    chk("R5 pulse at L-1", 1'b1);
    ticks(1);
    chk("R5 pulse ends at L", 1'b0);
    ticks(WD - 1);
    chk("R6 count cleared by reset", 1'b0);
    ticks(1);
    chk("R5 re-armed expiry", 1'b1);
    ticks(BASE);
    chk("R5 second pulse ends", 1'b0);

    wd_en = 1'b0;
    ticks(WD + 5);
    chk("R7 strap low after use", 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule